// File: doc/BRIEF.md
# Parallel Camera Frame Capture Controller

This block takes bytes from an image sensor on an 8-bit parallel bus, qualified by frame-valid and line-valid strobes and sampled on every rising edge of the capture clock (the pixel clock domain; any crossing happens outside). While enabled it opens a frame on the rising edge of frame-valid, counts bytes along each line and lines along the frame against programmed limits, and pushes every accepted byte into a receive FIFO that a DMA engine or other consumer drains through a show-ahead read port.

The programmed line limit is in units that depend on the colour mode: in raw mode every unit is one byte, in RGB565 mode every unit is one two-byte pixel. Both the line and frame limits are programmed as count minus one. A DMA request is raised while the FIFO holds at least the threshold level and DMA is enabled. A sticky, write-one-to-clear status vector records start of frame, end of frame, end of line, per-channel data available, per-channel overrun and quick-disable completion; per-class mask bits keep an event off the interrupt line without stopping it from being recorded.

Capture can be stopped two ways: a quick disable halts at once and flags completion, while a deferred disable lets the frame in flight finish and drops the enable at its end.

Top module: `cam_capture`

## Requirements
- R1: After reset `enabled_o` is 0, `status_o` is all zero, `irq_o` and `dma_req_o` are 0 and `fifo_empty_o` is 1.
- R2: A byte is written to the FIFO only while enabled, inside a frame opened by a rising edge of `frame_valid_i`, and while both `frame_valid_i` and `line_valid_i` are high; bytes are read out in arrival order.
- R3: A line holds `ppl_m1_i+1` bytes when `rgb_mode_i` is 0 and `2*(ppl_m1_i+1)` bytes when it is 1; the byte that reaches that count raises end of line (status bit 2) and further bytes are dropped until `line_valid_i` falls.
- R4: If `line_valid_i` falls before the limit, end of line is raised at the fall; a line that already ended by count raises no second end of line when `line_valid_i` falls.
- R5: Start of frame (status bit 0) is raised on the opening rising edge of `frame_valid_i`; end of frame (status bit 1) is raised by the end of line of line number `lpf_m1_i+1`, after which no byte is taken until the next frame.
- R6: `dma_req_o` is high exactly while `dma_en_i` is 1 and the FIFO holds at least 96 bytes; status bit 3 (data available, channel 0) is set on every cycle the FIFO holds at least 96 bytes.
- R7: A byte accepted while the 128-byte FIFO is full is dropped and sets status bit 6 (overrun, channel 0).
- R8: Status bits are sticky and cleared by a 1 on the matching bit of `status_clr_i`; an event in the same cycle wins over the clear. Bits 4, 5, 7 and 8 (channels 1 and 2) never set.
- R9: `mask_i` bit 0 masks start of frame, bit 1 end of frame, bit 2 end of line, bit 3 data available, bit 4 overrun; a masked event still sets its status bit but does not raise `irq_o`. Status bit 9 never raises `irq_o`.
- R10: A pulse on `quick_dis_i` drops `enabled_o` on the next cycle, takes no byte in that cycle or after, and sets status bit 9.
- R11: A pulse on `defer_dis_i` inside a frame keeps `enabled_o` high until the end of frame, which drops it in the same cycle; outside a frame `enabled_o` drops within two cycles.
- R12: A pulse on `en_set_i` sets `enabled_o` and cancels a pending deferred disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture (pixel) clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | Frame-valid strobe from the sensor |
| line_valid_i | input | 1 | Line-valid strobe from the sensor |
| pix_data_i | input | 8 | Sensor data byte |
| rgb_mode_i | input | 1 | 1: two bytes per line unit, 0: one byte |
| ppl_m1_i | input | 10 | Line length in units, minus one |
| lpf_m1_i | input | 9 | Lines per frame, minus one |
| dma_en_i | input | 1 | Lets the FIFO level drive the DMA request |
| mask_i | input | 5 | Per-class interrupt masks |
| en_set_i | input | 1 | Enable pulse |
| quick_dis_i | input | 1 | Immediate disable pulse |
| defer_dis_i | input | 1 | End-of-frame disable pulse |
| status_clr_i | input | 10 | Write-one-to-clear strobes for status |
| rd_en_i | input | 1 | Pop one FIFO byte |
| rd_data_o | output | 8 | FIFO head byte |
| fifo_empty_o | output | 1 | FIFO holds no byte |
| enabled_o | output | 1 | Capture enabled |
| status_o | output | 10 | Sticky event status |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |

## Verification
On every cycle the assertions hold the FIFO level inside its depth, keep a full FIFO full until a read, keep status bits sticky unless cleared, forbid any write while disabled, hold the enable through a pending deferred disable until end of frame, and tie the DMA request and interrupt to a non-empty FIFO and a set status bit. Only the bench scenarios show the byte-accurate line lengths in both colour modes, the early and late line endings, the frame count, the order of data in the FIFO, the threshold crossing, mask effects and the exact cycle the disables take hold.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int ST_W     = 10;
  localparam int MASK_W   = 5;
  localparam int ST_SOF   = 0;
  localparam int ST_EOF   = 1;
  localparam int ST_EOL   = 2;
  localparam int ST_RDAV0 = 3;
  localparam int ST_OVR0  = 6;
  localparam int ST_QD    = 9;
  localparam int N_CHAN   = 3;

  // mask class of a status bit (interrupting bits 0..8)
  function automatic int mask_class(int b);
    if (b < ST_RDAV0)     return b;
    else if (b < ST_OVR0) return 3;
    else                  return 4;
  endfunction
endpackage

// File: rtl/cam_fifo.sv
module cam_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [LVL_W-1:0]  level_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [LVL_W-1:0]  level_q;
  logic              do_wr, do_rd;

  assign full_o  = (level_q == LVL_W'(DEPTH));
  assign empty_o = (level_q == '0);
  assign do_wr   = wr_i && !full_o;
  assign do_rd   = rd_i && !empty_o;
  assign rdata_o = mem_q[rptr_q];
  assign level_o = level_q;

  function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (do_wr) wptr_q <= nxt(wptr_q);
      if (do_rd) rptr_q <= nxt(rptr_q);
      case ({do_wr, do_rd})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  a_r7_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LVL_W'(DEPTH));
  a_r7_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !rd_i) |=> full_o);
endmodule

// File: rtl/cam_framer.sv
module cam_framer #(
  parameter int PPL_W = 10,
  parameter int LPF_W = 9,
  localparam int CNT_W = PPL_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fv_i,
  input  logic             lv_i,
  input  logic             rgb_mode_i,
  input  logic [PPL_W-1:0] ppl_m1_i,
  input  logic [LPF_W-1:0] lpf_m1_i,
  input  logic             en_set_i,
  input  logic             quick_dis_i,
  input  logic             defer_dis_i,
  output logic             enabled_o,
  output logic             wr_o,
  output logic             sof_o,
  output logic             eof_o,
  output logic             eol_o,
  output logic             qd_o
);
  logic             enable_q, dis_pend_q, in_frame_q, fv_q, lv_q;
  logic             line_open_q, line_full_q;
  logic [CNT_W-1:0] byte_cnt_q, cnt_cur, unit_cnt, line_bytes;
  logic [LPF_W-1:0] line_cnt_q, lines_cur;
  logic             sof, active, accept, byte_last, lv_fall, eol, eof;

  always_comb begin
    unit_cnt   = CNT_W'(ppl_m1_i) + 1'b1;
    line_bytes = rgb_mode_i ? (unit_cnt << 1) : unit_cnt;
    sof        = enable_q && !dis_pend_q && !quick_dis_i && fv_i && !fv_q;
    active     = (in_frame_q || sof) && !quick_dis_i;
    accept     = active && fv_i && lv_i && !line_full_q;
    cnt_cur    = sof ? '0 : byte_cnt_q;
    lines_cur  = sof ? '0 : line_cnt_q;
    byte_last  = accept && (cnt_cur == line_bytes - 1'b1);
    lv_fall    = lv_q && !lv_i;
    eol        = byte_last || (active && !sof && lv_fall && line_open_q);
    eof        = eol && (lines_cur == lpf_m1_i);
  end

  assign enabled_o = enable_q;
  assign wr_o      = accept;
  assign sof_o     = sof;
  assign eof_o     = eof;
  assign eol_o     = eol;
  assign qd_o      = quick_dis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q    <= 1'b0;
      dis_pend_q  <= 1'b0;
      in_frame_q  <= 1'b0;
      fv_q        <= 1'b0;
      lv_q        <= 1'b0;
      line_open_q <= 1'b0;
      line_full_q <= 1'b0;
      byte_cnt_q  <= '0;
      line_cnt_q  <= '0;
    end else begin
      fv_q <= fv_i;
      lv_q <= lv_i;
      if (quick_dis_i) begin
        enable_q    <= 1'b0;
        dis_pend_q  <= 1'b0;
        in_frame_q  <= 1'b0;
        line_open_q <= 1'b0;
        line_full_q <= 1'b0;
      end else begin
        if (en_set_i) begin
          enable_q   <= 1'b1;
          dis_pend_q <= 1'b0;
        end else if (defer_dis_i) begin
          dis_pend_q <= 1'b1;
        end else if (dis_pend_q && (!in_frame_q || eof)) begin
          enable_q   <= 1'b0;
          dis_pend_q <= 1'b0;
        end

        if (eof)      in_frame_q <= 1'b0;
        else if (sof) in_frame_q <= 1'b1;

        if (eol)         byte_cnt_q <= '0;
        else if (accept) byte_cnt_q <= cnt_cur + 1'b1;
        else if (sof)    byte_cnt_q <= '0;

        if (eol)      line_cnt_q <= eof ? '0 : lines_cur + 1'b1;
        else if (sof) line_cnt_q <= '0;

        if (eol)         line_open_q <= 1'b0;
        else if (accept) line_open_q <= 1'b1;
        else if (sof)    line_open_q <= 1'b0;

        if (byte_last)            line_full_q <= 1'b1;
        else if (lv_fall || sof)  line_full_q <= 1'b0;
      end
    end
  end

  a_r2_no_write_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_q |-> !wr_o);
  a_r10_quick_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quick_dis_i |=> (!enable_q && !in_frame_q));
  a_r11_hold_to_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_q && dis_pend_q && in_frame_q && !eof && !quick_dis_i) |=> enable_q);
endmodule

// File: rtl/cam_irq.sv
module cam_irq import cam_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ST_W-1:0]   event_i,
  input  logic [ST_W-1:0]   clr_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [ST_W-1:0]   status_o,
  output logic              irq_o
);
  logic [ST_W-1:0] status_q;
  logic [ST_QD-1:0] bit_mask;

  for (genvar b = 0; b < ST_QD; b++) begin : g_mask
    assign bit_mask[b] = mask_i[mask_class(b)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | event_i;
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q[ST_QD-1:0] & ~bit_mask);

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(status_q & ~clr_i)) == $past(status_q & ~clr_i)));
  a_r9_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |status_q[ST_QD-1:0]);
endmodule

// File: rtl/cam_capture.sv
module cam_capture import cam_pkg::*; #(
  parameter int DATA_W     = 8,
  parameter int PPL_W      = 10,
  parameter int LPF_W      = 9,
  parameter int FIFO_DEPTH = 128,
  parameter int DMA_THRESH = 96,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_valid_i,
  input  logic              line_valid_i,
  input  logic [DATA_W-1:0] pix_data_i,
  input  logic              rgb_mode_i,
  input  logic [PPL_W-1:0]  ppl_m1_i,
  input  logic [LPF_W-1:0]  lpf_m1_i,
  input  logic              dma_en_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              en_set_i,
  input  logic              quick_dis_i,
  input  logic              defer_dis_i,
  input  logic [ST_W-1:0]   status_clr_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              fifo_empty_o,
  output logic              enabled_o,
  output logic [ST_W-1:0]   status_o,
  output logic              irq_o,
  output logic              dma_req_o
);
  logic             wr, sof, eof, eol, qd, full, above;
  logic [LVL_W-1:0] level;
  logic [ST_W-1:0]  events;

  cam_framer #(.PPL_W(PPL_W), .LPF_W(LPF_W)) u_framer (
    .clk_i, .rst_ni,
    .fv_i(frame_valid_i), .lv_i(line_valid_i),
    .rgb_mode_i, .ppl_m1_i, .lpf_m1_i,
    .en_set_i, .quick_dis_i, .defer_dis_i,
    .enabled_o, .wr_o(wr), .sof_o(sof), .eof_o(eof), .eol_o(eol), .qd_o(qd)
  );

  cam_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .wr_i(wr), .wdata_i(pix_data_i), .rd_i(rd_en_i),
    .rdata_o(rd_data_o), .full_o(full), .empty_o(fifo_empty_o), .level_o(level)
  );

  assign above = (level >= LVL_W'(DMA_THRESH));

  always_comb begin
    events              = '0;
    events[ST_SOF]      = sof;
    events[ST_EOF]      = eof;
    events[ST_EOL]      = eol;
    events[ST_RDAV0]    = above;
    events[ST_OVR0]     = wr && full;
    events[ST_QD]       = qd;
  end

  cam_irq u_irq (
    .clk_i, .rst_ni,
    .event_i(events), .clr_i(status_clr_i), .mask_i,
    .status_o, .irq_o
  );

  assign dma_req_o = dma_en_i && above;

  a_r6_dma_not_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> !fifo_empty_o);
endmodule

// File: tb/tb_cam_capture.sv
module tb_cam_capture;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       fv = 0, lv = 0, rgb = 0, dma_en = 0, en_set = 0, qdis = 0, ddis = 0, rd = 0;
  logic [7:0] pix = 0;
  logic [9:0] ppl = 0;
  logic [8:0] lpf = 0;
  logic [4:0] mask = 0;
  logic [9:0] sclr = 0;
  logic [7:0] rdata;
  logic       empty, enabled, irq, dreq;
  logic [9:0] status;

  int n_chk = 0, n_err = 0;
  logic [7:0] got [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_capture dut (
    .clk_i(clk), .rst_ni, .frame_valid_i(fv), .line_valid_i(lv), .pix_data_i(pix),
    .rgb_mode_i(rgb), .ppl_m1_i(ppl), .lpf_m1_i(lpf), .dma_en_i(dma_en), .mask_i(mask),
    .en_set_i(en_set), .quick_dis_i(qdis), .defer_dis_i(ddis), .status_clr_i(sclr),
    .rd_en_i(rd), .rd_data_o(rdata), .fifo_empty_o(empty), .enabled_o(enabled),
    .status_o(status), .irq_o(irq), .dma_req_o(dreq)
  );

  // {rgb, ppl_m1, lpf_m1, bytes driven per line, bytes kept per line}
  localparam logic [35:0] VEC [5] = '{
    {1'b0, 10'd3, 9'd1, 8'd4, 8'd4},
    {1'b1, 10'd3, 9'd1, 8'd8, 8'd8},
    {1'b0, 10'd5, 9'd2, 8'd3, 8'd3},
    {1'b0, 10'd2, 9'd1, 8'd6, 8'd3},
    {1'b1, 10'd1, 9'd2, 8'd6, 8'd4}
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic pulse_en();  en_set = 1; tick(); en_set = 0; endtask
  task automatic pulse_qd();  qdis = 1;   tick(); qdis = 0;   endtask
  task automatic pulse_dd();  ddis = 1;   tick(); ddis = 0;   endtask
  task automatic clr_all();   sclr = '1;  tick(); sclr = '0;  endtask

  task automatic send_line(int n, int base);
    for (int i = 0; i < n; i++) begin
      lv = 1; pix = 8'(base + i); tick();
    end
    lv = 0; tick();
  endtask

  task automatic drive_frame(int lines, int n);
    fv = 1; tick();
    for (int l = 0; l < lines; l++) send_line(n, l * 16);
    fv = 0; tick();
  endtask

  task automatic drain(output int n);
    n = 0;
    while (!empty && n < 256) begin
      got[n] = rdata; n++;
      rd = 1; tick();
    end
    rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int n, bad;
    repeat (3) tick();
    // R1 reset state
    chk("R1 enabled", int'(enabled), 0);
    chk("R1 status", int'(status), 0);
    chk("R1 irq/dma", int'({irq, dreq}), 0);
    chk("R1 empty", int'(empty), 1);
    rst_ni = 1; tick();

    // R3 R5 R2: table of frame shapes
    foreach (VEC[v]) begin
      logic [35:0] e;
      int lines, drv, keep;
      e = VEC[v];
      rgb = e[35]; ppl = e[34:25]; lpf = e[24:16];
      drv = int'(e[15:8]); keep = int'(e[7:0]); lines = int'(lpf) + 1;
      pulse_en(); clr_all();
      drive_frame(lines, drv);
      chk("R5 sof set", int'(status[0]), 1);
      chk("R5 eof set", int'(status[1]), 1);
      drain(n);
      chk("R3 bytes per frame", n, lines * keep);
      bad = 0;
      for (int l = 0; l < lines; l++)
        for (int i = 0; i < keep; i++)
          if (l * keep + i < n && got[l * keep + i] != 8'(l * 16 + i)) bad++;
      chk("R2 data order", bad, 0);
    end

    // R4: line ended by count, then late lv fall gives no second eol
    rgb = 0; ppl = 1; lpf = 1; pulse_en(); clr_all();
    fv = 1; tick();
    lv = 1; pix = 8'h11; tick(); pix = 8'h12; tick();
    chk("R4 eol on count", int'(status[2]), 1);
    sclr = 10'b100; pix = 8'h13; tick(); sclr = 0; pix = 8'h14; tick();
    lv = 0; tick(); tick();
    chk("R4 no second eol", int'(status[2]), 0);
    chk("R5 no early eof", int'(status[1]), 0);
    fv = 0; pulse_qd(); drain(n);
    chk("R3 extra bytes dropped", n, 2);

    // R2: disabled or outside frame-valid
    clr_all(); drive_frame(1, 3);
    chk("R2 disabled no sof", int'(status[0]), 0);
    chk("R2 disabled no data", int'(empty), 1);
    ppl = 9; lpf = 0; pulse_en();
    lv = 1; pix = 8'h55; tick(); tick(); lv = 0; tick();
    chk("R2 lv without fv", int'(empty), 1);

    // R6: threshold and DMA gate
    ppl = 199; lpf = 0; dma_en = 1; clr_all();
    drive_frame(1, 95);
    chk("R6 below threshold", int'(dreq), 0);
    drive_frame(1, 1);
    chk("R6 at threshold", int'(dreq), 1);
    chk("R6 rdav set", int'(status[3]), 1);
    dma_en = 0; #1;
    chk("R6 dma gated", int'(dreq), 0);
    tick(); dma_en = 1;
    sclr = 10'b1000; tick(); sclr = 0;
    chk("R8 set beats clear", int'(status[3]), 1);
    drain(n);
    chk("R6 drained count", n, 96);
    chk("R6 req drops", int'(dreq), 0);
    sclr = 10'b1000; tick(); sclr = 0;
    chk("R8 w1c clears", int'(status[3]), 0);

    // R7 overrun
    clr_all(); drive_frame(1, 130);
    chk("R7 overrun set", int'(status[6]), 1);
    chk("R8 ch1/ch2 zero", int'({status[8:7], status[5:4]}), 0);
    drain(n);
    chk("R7 kept count", n, 128);
    chk("R7 last kept byte", int'(got[127]), 127);
    dma_en = 0;

    // R9 masks
    ppl = 1; lpf = 0; mask = 5'b11111; clr_all();
    drive_frame(1, 2);
    chk("R9 masked status", int'(status[2:0]), 7);
    chk("R9 masked irq", int'(irq), 0);
    mask = 5'b11101; #1;
    chk("R9 eof unmasked", int'(irq), 1);
    tick(); mask = 0; clr_all(); drain(n);
    pulse_qd();
    chk("R9 qd no irq", int'({status[9], irq}), 2);

    // R10 quick disable mid line
    ppl = 9; lpf = 0; pulse_en(); clr_all();
    fv = 1; tick();
    lv = 1; pix = 8'hA0; tick(); pix = 8'hA1; tick();
    qdis = 1; pix = 8'hA2; tick(); qdis = 0;
    chk("R10 enable drops", int'(enabled), 0);
    pix = 8'hA3; tick(); lv = 0; fv = 0; tick();
    chk("R10 qd status", int'(status[9]), 1);
    drain(n);
    chk("R10 bytes kept", n, 2);

    // R11 deferred disable in a frame
    ppl = 2; lpf = 1; pulse_en(); clr_all();
    fv = 1; tick();
    send_line(3, 0);
    pulse_dd(); tick();
    chk("R11 held in frame", int'(enabled), 1);
    lv = 1; pix = 1; tick(); tick(); tick();
    chk("R11 drops at eof", int'({enabled, status[1]}), 1);
    lv = 0; fv = 0; tick(); drain(n);
    chk("R11 frame complete", n, 6);
    pulse_en(); pulse_dd(); tick();
    chk("R11 idle drop", int'(enabled), 0);

    // R12 enable cancels deferred disable
    pulse_en(); clr_all();
    fv = 1; tick();
    send_line(3, 0);
    pulse_dd(); pulse_en();
    send_line(3, 0);
    fv = 0; tick();
    chk("R12 still enabled", int'({enabled, status[1]}), 3);
    drain(n);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule